// File: doc/BRIEF.md
# Two-wire serial EEPROM target

This block models the target side of a two-wire serial EEPROM inside a synchronous design. A system clock that runs much faster than the serial clock samples the SCL and SDA lines. Each line goes through a two-flop synchronizer and then a sample-count glitch filter. The filtered lines are decoded into START and STOP conditions and into 8-bit words. The block answers on the bus through a single open-drain pull-low output, and the word store is an internal register array.

A controller writes by sending a device-select byte, a word address and up to one page of data, then closing with STOP. That STOP starts a self-timed write cycle. For as long as the cycle runs, the block raises a busy flag and ignores the bus completely, START included. To read, the controller either addresses the block in read mode (a current-address read) or first sets the word address with a dummy write and then issues a repeated START (a random read). It keeps acknowledging words to continue a sequential read. It ends the read by withholding its acknowledge and issuing STOP.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset the pull-low output is released (0) and the busy flag is 0.
- R2: A falling SDA while SCL is high is a START. Outside a write cycle it drops any partly received command, and decoding resumes at the device-select byte.
- R3: The device-select byte is, MSB first, the type code 1010, then the three select bits equal to the DEV_SEL parameter, then a direction bit (1 = read). Any other byte is not acknowledged, and the block then ignores the bus until the next START.
- R4: The block acknowledges each accepted received word (device select, word address, write data) by pulling SDA low during the ninth SCL clock. All words move MSB first.
- R5: Each write data byte is stored at the address counter. The counter then increments only within its 8-byte page (the low 3 bits wrap and the upper bits stay fixed).
- R6: A STOP that follows at least one accepted data byte starts a write cycle: busy is high for exactly WR_CYCLES clocks. A STOP with no data byte starts no write cycle.
- R7: During a write cycle every START, STOP and bit on the bus is ignored and nothing is acknowledged.
- R8: Reads return the byte at the address counter, and the counter then increments across the whole array, from the top address back to 0. A random read uses the address set by a preceding dummy write. A current-address read continues from where the last access left the counter.
- R9: If the controller does not acknowledge a read byte, the block releases SDA and ends the read. After the STOP it is in standby, and the next command is decoded normally.
- R10: A pulse on either line that is shorter than FILT_LEN system clocks is rejected and has no effect on the decoded traffic.
- R11: The pull-low output changes only after the block has seen SCL low. It stays constant while SCL is high.
- R12: After reset every array byte reads as 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin (wired level) |
| sda_pull_o | output | 1 | 1 pulls SDA low; 0 releases the line |
| busy_o | output | 1 | High while the internal write cycle runs |

## Verification
The bench builds the block with FILT_LEN = 5, which is 100 ns at 50 MHz. This lets a 2-clock pulse inside an SCL-high window act as a START-then-STOP glitch that the block must reject. WR_CYCLES is set to 2000 instead of the multi-millisecond default. That keeps several complete write cycles inside the run, and it still leaves room to send a whole START and device-select byte while the cycle is running. Each SCL bit lasts 60 system clocks, which keeps the line pipeline delay well inside each SCL phase. Because the page is 8 bytes and the array is 256 bytes, both the page wrap and the wrap from the top address back to 0 are reached with a few bytes.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int BYTE_W = 8;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEVACK,
    ST_ADR,
    ST_ADRACK,
    ST_WDAT,
    ST_WDACK,
    ST_RDAT,
    ST_RACK,
    ST_BUSY
  } eep_state_e;
endpackage

// File: rtl/eep_line_filter.sv
module eep_line_filter #(
  parameter int   FILT_LEN = 5,
  parameter logic IDLE_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(FILT_LEN - 1);
  localparam logic [CW-1:0] CNT_ONE  = CW'(1);

  logic          sync1_q, sync2_q;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          out_n;

  // two-flop synchronizer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= IDLE_VAL;
      sync2_q <= IDLE_VAL;
    end else begin
      sync1_q <= line_i;
      sync2_q <= sync1_q;
    end
  end

  // accept a new level only after it persisted FILT_LEN samples
  always_comb begin
    cnt_n = '0;
    out_n = line_o;
    if (sync2_q != line_o) begin
      if (cnt_q == CNT_LAST) begin
        out_n = sync2_q;
      end else begin
        cnt_n = cnt_q + CNT_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      line_o <= IDLE_VAL;
    end else begin
      cnt_q  <= cnt_n;
      line_o <= out_n;
    end
  end

  // R10: a new filtered level must have been present on the synchronized input
  assert_filter_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (line_o != $past(line_o)) |-> ($past(sync2_q) == line_o && $past(sync2_q, 2) == line_o));
endmodule

// File: rtl/eep_store.sv
module eep_store #(
  parameter int         AW     = 8,
  parameter logic [7:0] ERASED = 8'hFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] cells_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells_q[i] <= ERASED;
    end else if (we_i) begin
      cells_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = cells_q[addr_i];

  // R5: a store never lands on an unknown location
  assert_wr_addr_known_R5: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |-> !$isunknown(addr_i));
endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl
  import eep_pkg::*;
#(
  parameter int         AW        = 8,
  parameter int         PAGE_AW   = 3,
  parameter int         WR_CYCLES = 250000,
  parameter logic [2:0] DEV_SEL   = 3'b000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_f,
  input  logic          sda_f,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [7:0]    mem_wdata_o,
  input  logic [7:0]    mem_rdata_i,
  output logic          pull_o,
  output logic          busy_o
);
  localparam int WCW = $clog2(WR_CYCLES + 1);
  localparam logic [WCW-1:0]     WCNT_LAST = WCW'(WR_CYCLES - 1);
  localparam logic [WCW-1:0]     WCNT_ONE  = WCW'(1);
  localparam logic [AW-1:0]      ADDR_ONE  = AW'(1);
  localparam logic [PAGE_AW-1:0] PAGE_ONE  = PAGE_AW'(1);
  localparam logic [3:0]         BIT_LAST  = 4'd7;

  eep_state_e     st_q, st_n;
  logic [3:0]     bitc_q, bitc_n;
  logic [7:0]     sh_q, sh_n;
  logic           pull_q, pull_n;
  logic [AW-1:0]  addr_q, addr_n;
  logic           rw_q, rw_n;
  logic           pend_q, pend_n;
  logic           mack_q, mack_n;
  logic [WCW-1:0] wcnt_q, wcnt_n;
  logic           scl_q, sda_q;
  logic           mem_we;

  // bus events from the filtered lines
  logic scl_rise, scl_fall, start_ev, stop_ev, dev_match;
  logic [AW-1:0] page_inc;

  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign start_ev  = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_ev   = scl_f & scl_q & ~sda_q & sda_f;
  assign dev_match = (sh_q[7:4] == DEV_TYPE) && (sh_q[3:1] == DEV_SEL);
  assign page_inc  = {addr_q[AW-1:PAGE_AW], addr_q[PAGE_AW-1:0] + PAGE_ONE};

  always_comb begin
    st_n   = st_q;
    bitc_n = bitc_q;
    sh_n   = sh_q;
    pull_n = pull_q;
    addr_n = addr_q;
    rw_n   = rw_q;
    pend_n = pend_q;
    mack_n = mack_q;
    wcnt_n = wcnt_q;
    mem_we = 1'b0;
    if (st_q == ST_BUSY) begin
      // self-timed write cycle: the bus is not looked at
      if (wcnt_q == WCNT_LAST) begin
        st_n   = ST_IDLE;
        wcnt_n = '0;
      end else begin
        wcnt_n = wcnt_q + WCNT_ONE;
      end
    end else if (start_ev) begin
      st_n   = ST_DEV;
      bitc_n = '0;
      pull_n = 1'b0;
      pend_n = 1'b0;
    end else if (stop_ev) begin
      pull_n = 1'b0;
      bitc_n = '0;
      if (pend_q) begin
        st_n   = ST_BUSY;
        wcnt_n = '0;
        pend_n = 1'b0;
      end else begin
        st_n = ST_IDLE;
      end
    end else begin
      unique case (st_q)
        ST_DEV, ST_ADR, ST_WDAT: begin
          if (scl_rise && !bitc_q[3]) begin
            sh_n   = {sh_q[6:0], sda_f};
            bitc_n = bitc_q + 4'd1;
          end else if (scl_fall && bitc_q[3]) begin
            bitc_n = '0;
            if (st_q == ST_DEV) begin
              if (dev_match) begin
                pull_n = 1'b1;
                rw_n   = sh_q[0];
                st_n   = ST_DEVACK;
              end else begin
                st_n = ST_IDLE;
              end
            end else if (st_q == ST_ADR) begin
              pull_n = 1'b1;
              addr_n = sh_q;
              st_n   = ST_ADRACK;
            end else begin
              pull_n = 1'b1;
              mem_we = 1'b1;
              addr_n = page_inc;
              pend_n = 1'b1;
              st_n   = ST_WDACK;
            end
          end
        end
        ST_DEVACK, ST_ADRACK, ST_WDACK: begin
          if (scl_fall) begin
            pull_n = 1'b0;
            bitc_n = '0;
            if (st_q == ST_DEVACK && rw_q) begin
              st_n   = ST_RDAT;
              sh_n   = mem_rdata_i;
              pull_n = ~mem_rdata_i[7];
            end else if (st_q == ST_DEVACK) begin
              st_n = ST_ADR;
            end else begin
              st_n = ST_WDAT;
            end
          end
        end
        ST_RDAT: begin
          if (scl_fall) begin
            if (bitc_q == BIT_LAST) begin
              pull_n = 1'b0;
              bitc_n = '0;
              addr_n = addr_q + ADDR_ONE;
              st_n   = ST_RACK;
            end else begin
              sh_n   = {sh_q[6:0], 1'b0};
              pull_n = ~sh_q[6];
              bitc_n = bitc_q + 4'd1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_n = ~sda_f;
          end else if (scl_fall) begin
            if (mack_q) begin
              st_n   = ST_RDAT;
              sh_n   = mem_rdata_i;
              pull_n = ~mem_rdata_i[7];
              bitc_n = '0;
            end else begin
              st_n = ST_IDLE;
            end
          end
        end
        default: begin
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      bitc_q <= '0;
      sh_q   <= '0;
      pull_q <= 1'b0;
      addr_q <= '0;
      rw_q   <= 1'b0;
      pend_q <= 1'b0;
      mack_q <= 1'b0;
      wcnt_q <= '0;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      st_q   <= st_n;
      bitc_q <= bitc_n;
      sh_q   <= sh_n;
      pull_q <= pull_n;
      addr_q <= addr_n;
      rw_q   <= rw_n;
      pend_q <= pend_n;
      mack_q <= mack_n;
      wcnt_q <= wcnt_n;
      scl_q  <= scl_f;
      sda_q  <= sda_f;
    end
  end

  assign mem_we_o    = mem_we;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = sh_q;
  assign pull_o      = pull_q;
  assign busy_o      = (st_q == ST_BUSY);

  // R11: the line is only ever pulled in a cycle that followed a low SCL sample
  assert_pull_after_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull_q) |-> !$past(scl_f));

  // R7: nothing is driven while the write cycle runs
  assert_busy_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !pull_q);

  // R3: standby never drives the line
  assert_idle_no_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> !pull_q);

  // R5: a data byte never moves the counter out of its page
  assert_page_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WDACK && $past(st_q) == ST_WDAT) |->
      (addr_q[AW-1:PAGE_AW] == $past(addr_q[AW-1:PAGE_AW])));
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target #(
  parameter int         ADDR_W    = 8,
  parameter int         PAGE_W    = 3,
  parameter int         FILT_LEN  = 5,
  parameter int         WR_CYCLES = 250000,
  parameter logic [2:0] DEV_SEL   = 3'b000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_pull_o,
  output logic busy_o
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_lines, flt_lines;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0]        mem_wdata, mem_rdata;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    eep_line_filter #(
      .FILT_LEN (FILT_LEN),
      .IDLE_VAL (1'b1)
    ) u_flt (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (raw_lines[g]),
      .line_o (flt_lines[g])
    );
  end

  eep_ctrl #(
    .AW        (ADDR_W),
    .PAGE_AW   (PAGE_W),
    .WR_CYCLES (WR_CYCLES),
    .DEV_SEL   (DEV_SEL)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_f       (flt_lines[0]),
    .sda_f       (flt_lines[1]),
    .mem_we_o    (mem_we),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .mem_rdata_i (mem_rdata),
    .pull_o      (sda_pull_o),
    .busy_o      (busy_o)
  );

  eep_store #(
    .AW     (ADDR_W),
    .ERASED (8'hFF)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (mem_we),
    .addr_i  (mem_addr),
    .wdata_i (mem_wdata),
    .rdata_o (mem_rdata)
  );
endmodule

// File: tb/i2c_eeprom_target_tb_top.sv
`timescale 1ns/1ps
module i2c_eeprom_target_tb_top;
  localparam int FILT = 5;
  localparam int WRC  = 2000;

  logic clk = 1'b0;
  logic rst_n;
  logic scl_m, sda_m;
  wire  sda_line;
  logic sda_pull, busy;

  always #10 clk = ~clk;

  assign sda_line = sda_m & ~sda_pull;

  i2c_eeprom_target #(
    .ADDR_W(8), .PAGE_W(3), .FILT_LEN(FILT), .WR_CYCLES(WRC), .DEV_SEL(3'b000)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .busy_o(busy)
  );

  int n_chk = 0, n_bad = 0;
  int mem_m [256];
  int addr_m = 0;
  int run_len = 0, last_run = 0, runs = 0;
  int hi_cnt = 0, viol = 0;
  logic prev_pull = 1'b0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  // busy run length and SDA stability monitors
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) run_len++;
      else if (run_len != 0) begin
        last_run = run_len;
        runs++;
        run_len = 0;
      end
      if (scl_m) hi_cnt++; else hi_cnt = 0;
      if (hi_cnt > 2 && sda_pull != prev_pull) viol++;
      prev_pull = sda_pull;
    end
  end

  task automatic bus_start();
    sda_m = 1'b1; wt(10); scl_m = 1'b1; wt(30); sda_m = 1'b0; wt(30); scl_m = 1'b0; wt(20);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(10); scl_m = 1'b1; wt(30); sda_m = 1'b1; wt(30);
  endtask

  task automatic put_bit(bit b, bit glitch);
    sda_m = b; wt(10); scl_m = 1'b1;
    if (glitch && b) begin
      wt(10); sda_m = 1'b0; wt(2); sda_m = 1'b1; wt(18);
    end else wt(30);
    scl_m = 1'b0; wt(20);
  endtask

  task automatic get_bit(output bit b);
    sda_m = 1'b1; wt(10); scl_m = 1'b1; wt(15); b = sda_line; wt(15); scl_m = 1'b0; wt(20);
  endtask

  task automatic send_byte(logic [7:0] v, bit glitch, output bit acked);
    bit s;
    for (int i = 7; i >= 0; i--) put_bit(v[i], glitch);
    get_bit(s);
    acked = !s;
  endtask

  task automatic recv_byte(bit give_ack, output logic [7:0] v);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      get_bit(s);
      v[i] = s;
    end
    put_bit(!give_ack, 1'b0);
  endtask

  task automatic wait_cycle_end(string tag);
    int prev_runs;
    prev_runs = runs;
    for (int i = 0; i < WRC + 200 && busy; i++) wt(1);
    wt(2);
    chk({tag, " write cycle ended"}, runs, prev_runs + 1);
    chk({tag, " busy length"}, last_run, WRC);
  endtask

  // write n bytes starting at a; optional START probe during the cycle
  task automatic do_write(int a, int n, int base, bit probe);
    bit ak;
    logic [7:0] v;
    bus_start();
    send_byte(8'hA0, 1'b0, ak); chk("R4 dev-select ack", ak, 1);
    send_byte(8'(a), 1'b0, ak); chk("R4 address ack", ak, 1);
    addr_m = a;
    for (int i = 0; i < n; i++) begin
      v = 8'((base + i * 37) & 255);
      send_byte(v, 1'b0, ak); chk("R4 data ack", ak, 1);
      mem_m[addr_m] = v;
      addr_m = (addr_m & 8'hF8) | ((addr_m + 1) & 7);
    end
    bus_stop();
    wt(20);
    chk("R6 busy after STOP with data", busy, 1);
    if (probe) begin
      bus_start();
      send_byte(8'hA0, 1'b0, ak); chk("R7 no ack during write cycle", ak, 0);
      chk("R7 still busy", busy, 1);
      bus_stop();
    end
    wait_cycle_end("R6");
  endtask

  // read n bytes; a < 0 means current-address read
  task automatic do_read(int a, int n, string tag);
    bit ak;
    logic [7:0] v;
    bus_start();
    if (a >= 0) begin
      send_byte(8'hA0, 1'b0, ak); chk("R4 dummy-write select ack", ak, 1);
      send_byte(8'(a), 1'b0, ak); chk("R4 read address ack", ak, 1);
      addr_m = a;
      bus_start();
    end
    send_byte(8'hA1, 1'b0, ak); chk("R8 read select ack", ak, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, v);
      chk(tag, v, mem_m[addr_m]);
      addr_m = (addr_m + 1) & 255;
    end
    bus_stop();
    chk("R9 line released after NACK and STOP", sda_pull, 0);
  endtask

  initial begin
    bit ak;
    logic [7:0] v;
    for (int i = 0; i < 256; i++) mem_m[i] = 8'hFF;
    sda_m = 1'b1; scl_m = 1'b1; rst_n = 1'b0;
    wt(5); rst_n = 1'b1; wt(5);

    chk("R1 reset pull", sda_pull, 0);
    chk("R1 reset busy", busy, 0);

    // erased contents
    do_read(8'h33, 1, "R12 erased byte");

    // page write with a START probe during the write cycle
    do_write(8'h10, 3, 8'h21, 1'b1);
    do_read(8'h10, 3, "R8 random read sequential data");

    // page wrap on write
    do_write(8'h1E, 4, 8'h5C, 1'b0);
    do_read(8'h18, 8, "R5 page wrap contents");

    // full array wrap on read
    do_write(8'h00, 1, 8'h3D, 1'b0);
    do_write(8'hFE, 2, 8'h77, 1'b0);
    do_read(8'hFE, 3, "R8 array wrap read");

    // current-address read continues from the counter (now 0x01)
    do_read(-1, 2, "R8 current-address read");

    // non-matching select codes
    bus_start();
    send_byte(8'hA2, 1'b0, ak); chk("R3 wrong select bits not acked", ak, 0);
    send_byte(8'h00, 1'b0, ak); chk("R3 bus ignored after mismatch", ak, 0);
    bus_start();
    send_byte(8'hB0, 1'b0, ak); chk("R3 wrong type code not acked", ak, 0);
    bus_stop();
    chk("R3 no write cycle after mismatch", busy, 0);

    // START abandons a partial command
    bus_start();
    for (int i = 0; i < 4; i++) put_bit(i[0], 1'b0);
    bus_start();
    send_byte(8'hA0, 1'b0, ak); chk("R2 select acked after abandoned command", ak, 1);
    send_byte(8'h11, 1'b0, ak); chk("R2 address acked", ak, 1);
    addr_m = 8'h11;
    bus_start();
    send_byte(8'hA1, 1'b0, ak); chk("R2 read select acked after repeated START", ak, 1);
    recv_byte(1'b0, v);
    chk("R2 data after repeated START", v, mem_m[8'h11]);
    addr_m = 8'h12;
    bus_stop();

    // STOP without data starts no write cycle
    bus_start();
    send_byte(8'hA0, 1'b0, ak); chk("R4 select ack", ak, 1);
    send_byte(8'h20, 1'b0, ak); chk("R4 address ack", ak, 1);
    bus_stop();
    wt(20);
    chk("R6 no write cycle without data", busy, 0);

    // SDA glitch while SCL high must not look like START or STOP
    bus_start();
    send_byte(8'hA0, 1'b0, ak); chk("R4 select ack", ak, 1);
    send_byte(8'h40, 1'b0, ak); chk("R4 address ack", ak, 1);
    send_byte(8'hB7, 1'b1, ak); chk("R10 byte with glitches acked", ak, 1);
    send_byte(8'h5A, 1'b0, ak); chk("R10 following byte acked", ak, 1);
    bus_stop();
    mem_m[8'h40] = 8'hB7;
    mem_m[8'h41] = 8'h5A;
    wt(20);
    chk("R6 busy after glitched write", busy, 1);
    wait_cycle_end("R6");
    do_read(8'h40, 2, "R10 glitched write stored intact");

    chk("R11 SDA stable while SCL high", viol, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(negedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL all watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule